// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two parallel buses, called A and B, and passes data across in either direction through banks of level-sensitive latches. The datapath is cut into byte-wide sections. Every section has two latch banks, one per direction. Each bank has three active-low controls of its own: a chip-enable, a latch-enable and an output-enable. The sections can be run as separate byte-wide transceivers, or tied together by the system and run as one wide transceiver.

Three-state drive is made explicit so that it can be synthesized. Each bus side has an input word, an output word and one active-high drive-enable per section. The pad logic outside the block turns these into real three-state pins.

A direction loads from its source bus only while its chip-enable and latch-enable are both low. It drives its destination bus only while its chip-enable and output-enable are both low. When the latch-enable returns high, the bank keeps the last value it captured. While the chip-enable is high, that direction is fully idle. The latches have no reset, so a bank holds an undefined value until it has been loaded once.

Top module: `xcvr_bus16`

## Requirements
- R1: Section k owns data bits [8k+7:8k] of every bus word and is governed only by control bit k. Activity in one section leaves the stored data and the drive-enables of every other section unchanged.
- R2: With ab_ce_n[k]=0 and ab_le_n[k]=0, the A-to-B bank of section k is transparent. When its output is also enabled, b_out for that section follows a_in.
- R3: A rising ab_le_n[k] while ab_ce_n[k]=0 freezes the A-to-B bank at the value a_in had just before the edge. Later changes on a_in do not alter it.
- R4: b_oe[k] is 1 exactly when ab_ce_n[k]=0 and ab_oe_n[k]=0, and 0 otherwise. While b_oe[k] is 1, b_out for section k carries the bank's content.
- R5: Toggling ab_oe_n[k] changes only the drive state. The bank's content is the same when the output is enabled again.
- R6: While ab_ce_n[k]=1, b_oe[k] is 0 and the A-to-B bank is not loaded, whatever ab_le_n[k], ab_oe_n[k] and a_in do.
- R7: The B-to-A direction behaves in the same way (R2 to R6), using ba_ce_n, ba_le_n and ba_oe_n, with b_in as its source and a_out and a_oe as its destination.
- R8: If both directions of a section are commanded to drive at the same time, the block drives both a_out and b_out as commanded. Avoiding this contention is the system's job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | Value seen on the A bus |
| b_in | input | 16 | Value seen on the B bus |
| ab_ce_n | input | 2 | A-to-B chip-enable, active low, one bit per section |
| ab_le_n | input | 2 | A-to-B latch-enable, active low, one bit per section |
| ab_oe_n | input | 2 | A-to-B output-enable, active low, one bit per section |
| ba_ce_n | input | 2 | B-to-A chip-enable, active low, one bit per section |
| ba_le_n | input | 2 | B-to-A latch-enable, active low, one bit per section |
| ba_oe_n | input | 2 | B-to-A output-enable, active low, one bit per section |
| a_out | output | 16 | Value to drive onto the A bus (content of the B-to-A banks) |
| a_oe | output | 2 | A bus drive-enable, active high, one bit per section |
| b_out | output | 16 | Value to drive onto the B bus (content of the A-to-B banks) |
| b_oe | output | 2 | B bus drive-enable, active high, one bit per section |

## Verification
The bench builds the block with its default parameters: two sections of 8 bits each. At this size every byte value can be pushed through each of the four banks (two sections times two directions). For each value the bench checks transparency, hold after the latch-enable rise, output gating, and that loading is blocked while the chip-enable is high. With two sections present, the bench can confirm after each sweep that the three banks it did not touch still hold their own values. It also drives both directions of one section at once to show that contention is passed through rather than masked.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctl_t;

  function automatic logic ctl_loads(dir_ctl_t c);
    return !c.ce_n && !c.le_n;
  endfunction

  function automatic logic ctl_drives(dir_ctl_t c);
    return !c.ce_n && !c.oe_n;
  endfunction

endpackage

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank #(
  parameter int W = 8
) (
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  // Level-sensitive storage; contents start undefined (no reset by design).
  always_latch begin
    if (open_i) q_o = d_i;
  end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  dir_ctl_t     ctl_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] dst_o,
  output logic         drv_o
);

  logic load_open;

  always_comb begin
    load_open = ctl_loads(ctl_i);
    drv_o     = ctl_drives(ctl_i);
  end

  xcvr_latch_bank #(.W(W)) u_bank (
    .open_i (load_open),
    .d_i    (src_i),
    .q_o    (dst_o)
  );

  always_comb begin
    if (ctl_i.ce_n) AST_CE_MUTES_DRIVE: assert (!drv_o); // R6
    if (ctl_i.oe_n) AST_OE_MUTES_DRIVE: assert (!drv_o); // R4
    if (!ctl_i.ce_n && !ctl_i.le_n) AST_OPEN_FOLLOWS_SRC: assert (dst_o == src_i); // R2
  end

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  dir_ctl_t     ab_ctl_i,
  input  dir_ctl_t     ba_ctl_i,
  input  logic [W-1:0] a_in_i,
  input  logic [W-1:0] b_in_i,
  output logic [W-1:0] a_out_o,
  output logic [W-1:0] b_out_o,
  output logic         a_oe_o,
  output logic         b_oe_o
);

  xcvr_path #(.W(W)) u_ab (
    .ctl_i (ab_ctl_i),
    .src_i (a_in_i),
    .dst_o (b_out_o),
    .drv_o (b_oe_o)
  );

  xcvr_path #(.W(W)) u_ba (
    .ctl_i (ba_ctl_i),
    .src_i (b_in_i),
    .dst_o (a_out_o),
    .drv_o (a_oe_o)
  );

endmodule

// File: rtl/xcvr_bus16.sv
module xcvr_bus16
  import xcvr_pkg::*;
#(
  parameter int SECT_W = 8,
  parameter int N_SECT = 2,
  localparam int DW    = SECT_W * N_SECT
) (
  input  logic [DW-1:0]     a_in,
  input  logic [DW-1:0]     b_in,
  input  logic [N_SECT-1:0] ab_ce_n,
  input  logic [N_SECT-1:0] ab_le_n,
  input  logic [N_SECT-1:0] ab_oe_n,
  input  logic [N_SECT-1:0] ba_ce_n,
  input  logic [N_SECT-1:0] ba_le_n,
  input  logic [N_SECT-1:0] ba_oe_n,
  output logic [DW-1:0]     a_out,
  output logic [N_SECT-1:0] a_oe,
  output logic [DW-1:0]     b_out,
  output logic [N_SECT-1:0] b_oe
);

  for (genvar k = 0; k < N_SECT; k++) begin : g_sect
    dir_ctl_t ab_ctl;
    dir_ctl_t ba_ctl;

    always_comb begin
      ab_ctl = '{ce_n: ab_ce_n[k], le_n: ab_le_n[k], oe_n: ab_oe_n[k]};
      ba_ctl = '{ce_n: ba_ce_n[k], le_n: ba_le_n[k], oe_n: ba_oe_n[k]};
    end

    xcvr_section #(.W(SECT_W)) u_sect (
      .ab_ctl_i (ab_ctl),
      .ba_ctl_i (ba_ctl),
      .a_in_i   (a_in[k*SECT_W +: SECT_W]),
      .b_in_i   (b_in[k*SECT_W +: SECT_W]),
      .a_out_o  (a_out[k*SECT_W +: SECT_W]),
      .b_out_o  (b_out[k*SECT_W +: SECT_W]),
      .a_oe_o   (a_oe[k]),
      .b_oe_o   (b_oe[k])
    );

    always_comb begin
      AST_SECT_BOE_OWN_CTL: assert (b_oe[k] == (!ab_ce_n[k] && !ab_oe_n[k])); // R1
      AST_SECT_AOE_OWN_CTL: assert (a_oe[k] == (!ba_ce_n[k] && !ba_oe_n[k])); // R7
    end
  end

endmodule

// File: tb/sim_xcvr_bus16.sv
module sim_xcvr_bus16;
  localparam int CLK_P  = 10;
  localparam int SW     = 8;
  localparam int NS     = 2;
  localparam int DW     = SW * NS;
  localparam int WD_MAX = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [DW-1:0] a_in, b_in, a_out, b_out;
  logic [NS-1:0] ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
  logic [NS-1:0] a_oe, b_oe;

  int total = 0;
  int bad = 0;
  int usage_warn = 0;
  int cyc = 0;
  logic [SW-1:0] expv [2][NS];

  xcvr_bus16 #(.SECT_W(SW), .N_SECT(NS)) u0 (
    .a_in(a_in), .b_in(b_in),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_MAX) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_MAX);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Contention monitor: a usage error, never a design failure.
  always @(negedge clk) begin
    if (rst_n && ((a_oe & b_oe) != '0)) usage_warn = usage_warn + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // dir 0 = A-to-B, dir 1 = B-to-A
  task automatic set_ctl(int dir, int s, logic ce, logic le, logic oe);
    if (dir == 0) begin
      ab_ce_n[s] = ce; ab_le_n[s] = le; ab_oe_n[s] = oe;
    end else begin
      ba_ce_n[s] = ce; ba_le_n[s] = le; ba_oe_n[s] = oe;
    end
  endtask

  task automatic put_in(int dir, int s, logic [SW-1:0] v);
    if (dir == 0) a_in[s*SW +: SW] = v;
    else          b_in[s*SW +: SW] = v;
  endtask

  function automatic logic [SW-1:0] get_out(int dir, int s);
    return (dir == 0) ? b_out[s*SW +: SW] : a_out[s*SW +: SW];
  endfunction

  function automatic logic get_oe(int dir, int s);
    return (dir == 0) ? b_oe[s] : a_oe[s];
  endfunction

  // Read back every bank other than (xd, xs) through its output.
  task automatic verify_others(int xd, int xs);
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < NS; s++)
        if (!(d == xd && s == xs)) begin
          set_ctl(d, s, 1'b0, 1'b1, 1'b0);
          step();
          chk("R1 untouched bank", {31'd0, get_oe(d, s)}, 32'd1);
          chk("R1 untouched bank data", {24'd0, get_out(d, s)}, {24'd0, expv[d][s]});
          set_ctl(d, s, 1'b0, 1'b1, 1'b1);
        end
    step();
  endtask

  initial begin
    a_in = '0; b_in = '0;
    ab_ce_n = '1; ab_le_n = '1; ab_oe_n = '1;
    ba_ce_n = '1; ba_le_n = '1; ba_oe_n = '1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R6 idle a_oe", {30'd0, a_oe}, 32'd0);
    chk("R6 idle b_oe", {30'd0, b_oe}, 32'd0);

    // Preload all four banks with distinct values.
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < NS; s++) begin
        expv[d][s] = 8'h11 * (1 + 2*d + s);
        put_in(d, s, expv[d][s]);
        set_ctl(d, s, 1'b0, 1'b0, 1'b1);
        step();
        set_ctl(d, s, 1'b0, 1'b1, 1'b1);
        step();
      end

    for (int d = 0; d < 2; d++)
      for (int s = 0; s < NS; s++) begin
        for (int v = 0; v < 256; v++) begin
          logic [SW-1:0] val;
          val = v[SW-1:0];
          // R2 / R7 transparency
          set_ctl(d, s, 1'b0, 1'b0, 1'b0);
          put_in(d, s, val);
          step();
          chk(d == 0 ? "R2 transparent" : "R7 transparent", {24'd0, get_out(d, s)}, {24'd0, val});
          chk("R4 drive on", {31'd0, get_oe(d, s)}, 32'd1);
          // R3 hold after latch-enable rise
          set_ctl(d, s, 1'b0, 1'b1, 1'b0);
          step();
          put_in(d, s, ~val);
          step();
          chk(d == 0 ? "R3 hold" : "R7 hold", {24'd0, get_out(d, s)}, {24'd0, val});
          // R4 / R5 output gating keeps contents
          set_ctl(d, s, 1'b0, 1'b1, 1'b1);
          step();
          chk("R4 drive off", {31'd0, get_oe(d, s)}, 32'd0);
          set_ctl(d, s, 1'b0, 1'b1, 1'b0);
          step();
          chk("R5 content kept", {24'd0, get_out(d, s)}, {24'd0, val});
          // R6 chip-enable high blocks load and drive
          set_ctl(d, s, 1'b1, 1'b0, 1'b0);
          put_in(d, s, val ^ 8'h5A);
          step();
          chk("R6 no drive", {31'd0, get_oe(d, s)}, 32'd0);
          set_ctl(d, s, 1'b1, 1'b1, 1'b0);
          step();
          set_ctl(d, s, 1'b0, 1'b1, 1'b0);
          step();
          chk("R6 no load", {24'd0, get_out(d, s)}, {24'd0, val});
          set_ctl(d, s, 1'b0, 1'b1, 1'b1);
          expv[d][s] = val;
        end
        verify_others(d, s);
      end

    // R8: both directions of section 0 driving together
    set_ctl(0, 0, 1'b0, 1'b1, 1'b0);
    set_ctl(1, 0, 1'b0, 1'b1, 1'b0);
    step();
    chk("R8 both drive a_oe", {31'd0, a_oe[0]}, 32'd1);
    chk("R8 both drive b_oe", {31'd0, b_oe[0]}, 32'd1);
    chk("R8 b_out data", {24'd0, b_out[SW-1:0]}, {24'd0, expv[0][0]});
    chk("R8 a_out data", {24'd0, a_out[SW-1:0]}, {24'd0, expv[1][0]});
    chk("R1 section 1 quiet", {30'd0, a_oe[1], b_oe[1]}, 32'd0);
    set_ctl(0, 0, 1'b1, 1'b1, 1'b1);
    set_ctl(1, 0, 1'b1, 1'b1, 1'b1);
    step();
    if (usage_warn == 0) $display("note: expected contention warning not seen");
    else $display("usage warning: bus contention seen in %0d cycles", usage_warn);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule